// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a memory-mapped event timer. A 64-bit up-counter advances one step per clock while the global run bit is set. Three comparators (the count is a parameter, two to eight) each hold a compare value and can raise an interrupt when the counter reaches it. A comparator can be one-shot or periodic. A one-shot comparator is armed by software, which writes the current count plus a delay. A periodic comparator adds a stored period to its compare value every time it fires. A value-set handshake bit lets one compare write load both the compare value and that period.

Software reaches every register over a simple 64-bit bus. A write strobe, a byte address and write data are applied in one clock. Read data is combinational from the address. Each comparator's interrupt drives one of 32 output lines, chosen by its route field. Each interrupt is either a one-clock pulse (edge) or a status-backed level that software clears by writing 1. A legacy flag moves comparator 0 onto line 0 and comparator 1 onto line 8, whatever their route fields hold.

Each comparator runs a small state machine. `CMP_OFF` is the state with no interrupt enabled or the counter stopped. `CMP_ARMED` is the state where the comparator is enabled and waiting. `CMP_LATCHED` is the state where a level interrupt is pending in status. The transitions are:
- OFF→ARMED when the interrupt enable and the run bit are both set.
- ARMED→OFF when either of them drops.
- OFF or ARMED→LATCHED on a match in level mode.
- LATCHED→ARMED or LATCHED→OFF when software clears the status bit.

Top module: `evt_timer`

## Requirements
- R1: The word at offset 0x000 is read-only, and writes to it change nothing. Its fields are: bits 7:0 revision (default 0x01), bits 12:8 comparator count minus one, bit 13 set (64-bit counter), bit 15 set (legacy routing supported), bit 14 zero, bits 31:16 vendor ID (default 0xA5C3), bits 63:32 tick period in femtoseconds (default 10,000,000, which must not exceed 100,000,000). The default read value is 0x00989680_A5C3A201.
- R2: At offset 0x010, bit 0 is the run bit and bit 1 is the legacy flag. While the run bit is 1 the counter at 0xF0 rises by exactly 1 per clock. While it is 0 the counter holds. A write to 0xF0 loads the counter in either case and takes priority over the increment.
- R3: Comparator n has its configuration at 0x100+0x20·n, its compare value at +0x08 and a routing word at +0x10 that reads zero. It fires when the counter equals its compare value, its enable bit (bit 2) is set and the run bit is set. With the enable bit clear it never fires. A one-shot comparator leaves its compare value unchanged after firing.
- R4: The periodic bit (bit 3) can be set only on a comparator whose read-only bit 4 reads 1. By default comparators 0 and 1 have bit 4 set and comparator 2 does not. Bit 5 always reads 1. When a periodic comparator fires, its stored period is added to its compare value.
- R5: When the value-set bit (bit 6) is 1, the next compare write loads both the compare value and the period, and bit 6 then reads 0. A compare write with bit 6 at 0 leaves the period unchanged.
- R6: In level mode (bit 1 = 1), a firing comparator sets status bit n at 0x020. Its line stays high while that bit and the enable bit are both 1. Writing 1 to the status bit clears it. Writing 0 leaves it set.
- R7: In edge mode (bit 1 = 0), the line is high for exactly the clock after the one in which the counter equals the compare value, and the status bit stays 0.
- R8: Bits 13:9 select the output line. A write of a route whose bit in the read-only mask (bits 63:32, default 0x0000FFFE) is 0 leaves the route unchanged.
- R9: With the legacy flag set, comparator 0 drives line 0 and comparator 1 drives line 8, and their route fields have no effect.
- R10: After reset: the counter, the 0x010 word and the status word are 0, every compare value is all ones, every enable bit is 0, and all output lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address, 8-byte aligned |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| irq_lines | output | 32 | Interrupt output lines |

## Verification
A comparator state machine stuck in the wrong state shows at the ports within one clock of the match. Either the status word at 0x020 fails to show a pending bit, or a line stays high after software has cleared the bit. A wrong periodic reload or period capture shows up as a changed compare value on the next read-back, and as pulses at the wrong spacing on the routed line. A counter that steps while stopped, or skips steps while running, shows up as a mismatch between two counter reads a known number of clocks apart.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 64;
    localparam int ROUTE_W = 5;
    localparam int LINES   = 1 << ROUTE_W;

    localparam logic [ADDR_W-1:0] OFF_CAP = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_STS = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CNT = 12'h0F0;

    typedef enum logic [1:0] {
        CMP_OFF,
        CMP_ARMED,
        CMP_LATCHED
    } cmp_state_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter import evt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (ld)  count <= ld_val;
        else if (run) count <= count + 1'b1;
    end
endmodule

// File: rtl/evt_comparator.sv
module evt_comparator import evt_pkg::*; #(
    parameter bit          PER_CAP    = 1'b1,
    parameter logic [31:0] ROUTE_MASK = 32'h0000_FFFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  count,
    input  logic               run,
    input  logic               cfg_we,
    input  logic               cmp_we,
    input  logic               sts_clr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  cfg_word,
    output logic [DATA_W-1:0]  cmp_word,
    output logic [ROUTE_W-1:0] route,
    output logic               latched,
    output logic               level,
    output logic               fire,
    output logic               irq
);
    cmp_state_e        state_q, state_d;
    logic              ie_q, per_mode_q, vs_q, pulse_q;
    logic [DATA_W-1:0] cmp_q, period_q;

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level      <= 1'b0;
            ie_q       <= 1'b0;
            per_mode_q <= 1'b0;
            vs_q       <= 1'b0;
            route      <= '0;
        end else if (cfg_we) begin
            level      <= wdata[1];
            ie_q       <= wdata[2];
            per_mode_q <= wdata[3] & PER_CAP;
            vs_q       <= wdata[6];
            if (ROUTE_MASK[wdata[9 +: ROUTE_W]]) route <= wdata[9 +: ROUTE_W];
        end else if (cmp_we) begin
            vs_q <= 1'b0;
        end
    end

    assign fire = ie_q && run && (count == cmp_q);

    // compare value, period and edge pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q    <= '1;
            period_q <= '0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= fire && !level;
            if (cmp_we) begin
                cmp_q <= wdata;
                if (vs_q) period_q <= wdata;
            end else if (fire && per_mode_q) begin
                cmp_q <= cmp_q + period_q;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_OFF: begin
                if (fire && level)     state_d = CMP_LATCHED;
                else if (ie_q && run)  state_d = CMP_ARMED;
            end
            CMP_ARMED: begin
                if (fire && level)     state_d = CMP_LATCHED;
                else if (!(ie_q && run)) state_d = CMP_OFF;
            end
            CMP_LATCHED: begin
                if (sts_clr && !fire)  state_d = (ie_q && run) ? CMP_ARMED : CMP_OFF;
            end
            default:                   state_d = CMP_OFF;
        endcase
    end

    // outputs
    always_comb begin
        latched  = (state_q == CMP_LATCHED);
        irq      = level ? (latched && ie_q) : pulse_q;
        cmp_word = cmp_q;
        cfg_word = {ROUTE_MASK, 18'b0, route, 2'b00, vs_q, 1'b1, PER_CAP,
                    per_mode_q, ie_q, level, 1'b0};
    end
endmodule

// File: rtl/evt_router.sv
module evt_router import evt_pkg::*; #(
    parameter int NUM_CMP   = 3,
    parameter int LEG_LINE0 = 0,
    parameter int LEG_LINE1 = 8
) (
    input  logic [NUM_CMP-1:0]         irq_in,
    input  logic [NUM_CMP*ROUTE_W-1:0] routes,
    input  logic                       legacy,
    output logic [LINES-1:0]           lines
);
    logic [LINES-1:0] vec [NUM_CMP];

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_map
        logic [ROUTE_W-1:0] sel;
        if (c == 0) begin : g_l0
            assign sel = legacy ? ROUTE_W'(LEG_LINE0) : routes[c*ROUTE_W +: ROUTE_W];
        end else if (c == 1) begin : g_l1
            assign sel = legacy ? ROUTE_W'(LEG_LINE1) : routes[c*ROUTE_W +: ROUTE_W];
        end else begin : g_rt
            assign sel = routes[c*ROUTE_W +: ROUTE_W];
        end
        assign vec[c] = LINES'(irq_in[c]) << sel;
    end

    always_comb begin
        lines = '0;
        for (int c = 0; c < NUM_CMP; c++) lines = lines | vec[c];
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_pkg::*; #(
    parameter int          NUM_CMP      = 3,
    parameter logic [7:0]  REVISION     = 8'h01,
    parameter logic [15:0] VENDOR       = 16'hA5C3,
    parameter logic [31:0] TICK_FS      = 32'd10_000_000,
    parameter logic [31:0] PERIODIC_CAP = 32'h0000_0003,
    parameter logic [31:0] ROUTE_MASK   = 32'h0000_FFFE,
    parameter int          LEG_LINE0    = 0,
    parameter int          LEG_LINE1    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LINES-1:0]  irq_lines
);
    localparam logic [3:0]        NCMP4   = 4'(NUM_CMP);
    localparam logic [DATA_W-1:0] CAP_VAL = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1,
                                             5'(NUM_CMP - 1), REVISION};

    logic                       gen_q, leg_q, cnt_ld, sts_wr, cfg_wr, is_cmp;
    logic [2:0]                 cidx;
    logic [1:0]                 sub;
    logic [DATA_W-1:0]          cnt_q;
    logic [DATA_W-1:0]          cfg_w [NUM_CMP];
    logic [DATA_W-1:0]          cmp_w [NUM_CMP];
    logic [NUM_CMP-1:0]         sts_v, fire_v, lvl_v, irq_v;
    logic [NUM_CMP*ROUTE_W-1:0] routes;

    assign cidx   = addr[7:5];
    assign sub    = addr[4:3];
    assign is_cmp = (addr[11:8] == 4'h1) && ({1'b0, cidx} < NCMP4);
    assign cnt_ld = wr_en && (addr == OFF_CNT);
    assign sts_wr = wr_en && (addr == OFF_STS);
    assign cfg_wr = wr_en && (addr == OFF_CFG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= 1'b0;
            leg_q <= 1'b0;
        end else if (cfg_wr) begin
            gen_q <= wdata[0];
            leg_q <= wdata[1];
        end
    end

    evt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .run(gen_q), .ld(cnt_ld),
        .ld_val(wdata), .count(cnt_q)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        evt_comparator #(
            .PER_CAP(PERIODIC_CAP[g]), .ROUTE_MASK(ROUTE_MASK)
        ) u_cmp (
            .clk(clk), .rst_n(rst_n), .count(cnt_q), .run(gen_q),
            .cfg_we(wr_en && is_cmp && cidx == 3'(g) && sub == 2'd0),
            .cmp_we(wr_en && is_cmp && cidx == 3'(g) && sub == 2'd1),
            .sts_clr(sts_wr && wdata[g]),
            .wdata(wdata),
            .cfg_word(cfg_w[g]), .cmp_word(cmp_w[g]),
            .route(routes[g*ROUTE_W +: ROUTE_W]),
            .latched(sts_v[g]), .level(lvl_v[g]), .fire(fire_v[g]), .irq(irq_v[g])
        );
    end

    evt_router #(.NUM_CMP(NUM_CMP), .LEG_LINE0(LEG_LINE0), .LEG_LINE1(LEG_LINE1)) u_rt (
        .irq_in(irq_v), .routes(routes), .legacy(leg_q), .lines(irq_lines)
    );

    always_comb begin
        rdata = '0;
        if (is_cmp) begin
            case (sub)
                2'd0:    rdata = cfg_w[cidx];
                2'd1:    rdata = cmp_w[cidx];
                default: rdata = '0;
            endcase
        end else begin
            case (addr)
                OFF_CAP: rdata = CAP_VAL;
                OFF_CFG: rdata = {62'b0, leg_q, gen_q};
                OFF_STS: rdata = DATA_W'(sts_v);
                OFF_CNT: rdata = cnt_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk import evt_pkg::*; #(
    parameter int NUM_CMP   = 3,
    parameter int LEG_LINE0 = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gen_q,
    input logic               leg_q,
    input logic               cnt_ld,
    input logic               sts_wr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  cnt_q,
    input logic [NUM_CMP-1:0] sts_v,
    input logic [NUM_CMP-1:0] fire_v,
    input logic [NUM_CMP-1:0] lvl_v,
    input logic [NUM_CMP-1:0] irq_v,
    input logic [LINES-1:0]   irq_lines
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q && !cnt_ld) |=> (cnt_q == $past(cnt_q) + 64'd1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_q && !cnt_ld) |=> $stable(cnt_q)); // R2
    AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_v[0] && lvl_v[0]) |=> sts_v[0]); // R6
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && wdata[0] && !fire_v[0]) |=> !sts_v[0]); // R6
    AST_LEG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_q && irq_v[0]) |-> irq_lines[LEG_LINE0]); // R9
endmodule

bind evt_timer evt_timer_chk #(.NUM_CMP(NUM_CMP), .LEG_LINE0(LEG_LINE0)) chk_i (
    .clk(clk), .rst_n(rst_n), .gen_q(gen_q), .leg_q(leg_q), .cnt_ld(cnt_ld),
    .sts_wr(sts_wr), .wdata(wdata), .cnt_q(cnt_q), .sts_v(sts_v), .fire_v(fire_v),
    .lvl_v(lvl_v), .irq_v(irq_v), .irq_lines(irq_lines)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/100ps
module evt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [31:0] irq_lines;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    evt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines)
    );

    // reset-state read table: {address, expected value}
    localparam int NV = 10;
    localparam logic [75:0] RST_VEC [NV] = '{
        {12'h000, 64'h00989680_A5C3A201},
        {12'h010, 64'h0},
        {12'h020, 64'h0},
        {12'h0F0, 64'h0},
        {12'h100, 64'h0000FFFE_00000030},
        {12'h108, 64'hFFFFFFFF_FFFFFFFF},
        {12'h110, 64'h0},
        {12'h120, 64'h0000FFFE_00000030},
        {12'h140, 64'h0000FFFE_00000020},
        {12'h148, 64'hFFFFFFFF_FFFFFFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] v, a0;
        int p_main, p_other, first;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1 / R3 / R4 / R8: reset values through the read table
        for (int i = 0; i < NV; i++) begin
            rd(RST_VEC[i][75:64], v);
            chk($sformatf("R10 reset read @%h", RST_VEC[i][75:64]), v, RST_VEC[i][63:0]);
        end
        chk("R10 lines idle", 64'(irq_lines), 64'h0);

        // R1: capability word ignores writes
        wr(12'h000, 64'h0);
        rd(12'h000, v);
        chk("R1 cap read-only", v, 64'h00989680_A5C3A201);

        // R2: counter step, hold and load
        wr(12'h0F0, 64'd1000);
        rd(12'h0F0, v);
        chk("R2 load while stopped", v, 64'd1000);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd(12'h0F0, v);
        chk("R2 hold while stopped", v, 64'd1000);
        wr(12'h010, 64'h1);
        rd(12'h0F0, a0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd(12'h0F0, v);
        chk("R2 step of one per clock", v, a0 + 64'd5);
        wr(12'h0F0, 64'd77);
        rd(12'h0F0, v);
        chk("R2 load while running", v, 64'd77);
        wr(12'h010, 64'h0);

        // R6: level mode on comparator 0, route 12
        wr(12'h0F0, 64'd0);
        wr(12'h108, 64'd5);
        wr(12'h100, 64'h1806);
        rd(12'h020, v);
        chk("R6 no status before match", v, 64'h0);
        wr(12'h010, 64'h1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        rd(12'h020, v);
        chk("R6 status set", v, 64'h1);
        chk("R6 level line high", 64'(irq_lines[12]), 64'h1);
        wr(12'h020, 64'h0);
        rd(12'h020, v);
        chk("R6 write 0 keeps status", v, 64'h1);
        wr(12'h020, 64'h1);
        rd(12'h020, v);
        chk("R6 write 1 clears status", v, 64'h0);
        chk("R6 line low after clear", 64'(irq_lines[12]), 64'h0);
        rd(12'h108, v);
        chk("R3 one-shot compare unchanged", v, 64'd5);

        // R7: edge mode on comparator 0, route 10, compare 7
        wr(12'h010, 64'h0);
        wr(12'h100, 64'h1404);
        wr(12'h0F0, 64'd0);
        wr(12'h108, 64'd7);
        wr(12'h010, 64'h1);
        p_main = 0; first = -1;
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_lines[10]) begin
                p_main++;
                if (first < 0) first = i;
            end
        end
        chk("R7 single pulse", 64'(p_main), 64'd1);
        chk("R7 pulse in clock after match", 64'(first), 64'd8);
        rd(12'h020, v);
        chk("R7 edge leaves status clear", v, 64'h0);

        // R9: legacy flag moves comparator 0 to line 0
        wr(12'h010, 64'h0);
        wr(12'h0F0, 64'd0);
        wr(12'h108, 64'd4);
        wr(12'h010, 64'h3);
        p_main = 0; p_other = 0;
        for (int i = 1; i <= 10; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_lines[0])  p_main++;
            if (irq_lines[10]) p_other++;
        end
        chk("R9 legacy line 0 pulses", 64'(p_main), 64'd1);
        chk("R9 route field ignored", 64'(p_other), 64'd0);
        wr(12'h010, 64'h0);
        wr(12'h100, 64'h0);

        // R4 / R5: periodic comparator 1 with value-set, route 11
        wr(12'h0F0, 64'd0);
        wr(12'h120, 64'h164C);
        wr(12'h128, 64'd10);
        rd(12'h120, v);
        chk("R5 value-set self clears", v, 64'h0000FFFE_0000163C);
        wr(12'h010, 64'h1);
        p_main = 0;
        for (int i = 1; i <= 45; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_lines[11]) p_main++;
        end
        chk("R4 periodic pulse count", 64'(p_main), 64'd4);
        rd(12'h128, v);
        chk("R4 compare advanced by period", v, 64'd50);
        wr(12'h010, 64'h0);
        wr(12'h0F0, 64'd0);
        wr(12'h128, 64'd3);
        wr(12'h010, 64'h1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        rd(12'h128, v);
        chk("R5 period kept without value-set", v, 64'd23);
        wr(12'h010, 64'h0);

        // R8: route outside the mask is refused
        wr(12'h120, 64'h2804);
        rd(12'h120, v);
        chk("R8 masked route ignored", 64'(v[13:9]), 64'd11);

        // R4: comparator 2 cannot be periodic
        wr(12'h140, 64'h000C);
        rd(12'h140, v);
        chk("R4 periodic refused on incapable", 64'(v[4:3]), 64'd0);

        // R3: disabled comparator never fires
        wr(12'h120, 64'h0);
        wr(12'h140, 64'h1A02);
        wr(12'h0F0, 64'd0);
        wr(12'h148, 64'd3);
        wr(12'h010, 64'h1);
        p_main = 0;
        for (int i = 1; i <= 10; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_lines != 32'h0) p_main++;
        end
        chk("R3 disabled comparator silent", 64'(p_main), 64'd0);
        rd(12'h020, v);
        chk("R3 disabled comparator no status", v, 64'h0);
        rd(12'h150, v);
        chk("R3 routing word reads zero", v, 64'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule